// File: doc/BRIEF.md
# Soft-Stepped Channel Gain and Mute Controller

This block drives the gain setting of one audio channel. A control source supplies a 7-bit target gain code with 0.5 dB per code starting at 0 dB. The block moves its applied code toward that target one code at a time, paced by a once-per-sample strobe, so that the gain does not change abruptly. Any code above 59.5 dB saturates at the 59.5 dB code. A 2-bit mode selects the pace:

- one step per sample;
- one step every second sample;
- no stepping, where the applied code jumps straight to the target.

The block also passes through a mute request and a channel power request as registered status. It reports whether the applied gain has reached the target. The multiplier that applies the gain to samples sits outside this block.

All pins are plain control and status levels sampled on the clock. No data stream crosses the block's edge, so it has no valid/ready handshake and no back-pressure. The strobe is a one-cycle pulse and is the only pacing input.

Top module: `gain_slew_ctrl`

## Requirements
- R1: During and right after reset, the applied gain is 0, the effective mute is 1, the power status is 0 and the at-target flag is 0.
- R2: With mode 2'b00 and power on, each strobe cycle moves the applied gain by exactly one code toward the saturated target. It never overshoots, and it does not move when already equal to the target.
- R3: With mode 2'b01, steps happen only on every second strobe. The strobe count restarts at zero whenever the mode is not 2'b01 or power is off, so the first step comes on the second strobe.
- R4: With mode 2'b10 or 2'b11, the applied gain takes the saturated target value in the cycle after a strobe.
- R5: In a cycle without a strobe, the applied gain does not change while power is on.
- R6: Target codes above 7'h77 are treated as 7'h77 (59.5 dB), so the applied gain never exceeds 7'h77.
- R7: The at-target flag is 1 exactly when power status is 1 and the applied gain equals the saturated current target. The flag follows the target input in the same cycle.
- R8: While the power request is 0, the applied gain is forced to 0 at the next edge. After power returns, ramping starts from 0.
- R9: The effective mute equals the mute request of the previous cycle. The gain ramp continues while muted.
- R10: The power status equals the power request of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gain_set_i | input | 7 | Target gain code, 0.5 dB per code |
| mute_set_i | input | 1 | Mute request |
| step_mode_i | input | 2 | 00 every strobe, 01 every second strobe, 1x jump |
| power_on_i | input | 1 | Channel power request |
| fs_strobe_i | input | 1 | One-cycle pulse per sample period |
| gain_applied_o | output | 7 | Current applied gain code |
| mute_eff_o | output | 1 | Effective mute |
| at_target_o | output | 1 | Applied gain equals saturated target |
| power_state_o | output | 1 | Registered channel power state |

## Verification
The assertions assume that reset is applied from time zero and that the strobe is a plain one-cycle level. They place no limit on how often the strobe fires, and they allow any target code, including the saturating ones. The random stimulus fires the strobe on about a third of the cycles and changes the target often, with a bias toward codes above 7'h77. It switches modes occasionally and drops power rarely, so that long ramps, the alternate-strobe pacing and restarts from zero are all reached. Directed sequences add a full ramp into saturation, a jump in each disabled mode, and a mode-01 count restart.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  typedef enum logic [1:0] {
    STEP_EVERY = 2'b00,
    STEP_ALT   = 2'b01,
    STEP_JUMP0 = 2'b10,
    STEP_JUMP1 = 2'b11
  } step_mode_e;
endpackage

// File: rtl/gsc_clamp.sv
module gsc_clamp #(
  parameter int GAIN_W   = 7,
  parameter int SAT_CODE = 119
) (
  input  logic [GAIN_W-1:0] code_i,
  output logic [GAIN_W-1:0] code_o
);
  localparam logic [GAIN_W-1:0] LIMIT = GAIN_W'(SAT_CODE);

  always_comb begin
    code_o = (code_i > LIMIT) ? LIMIT : code_i;
  end
endmodule

// File: rtl/gsc_pacer.sv
module gsc_pacer
  import gsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       power_i,
  input  logic       strobe_i,
  input  step_mode_e mode_i,
  output logic       tick_o,
  output logic       jump_o
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else if (!power_i || mode_i != STEP_ALT) begin
      phase_q <= 1'b0;
    end else if (strobe_i) begin
      phase_q <= ~phase_q;
    end
  end

  always_comb begin
    jump_o = mode_i[1];
    tick_o = strobe_i && power_i && ((mode_i != STEP_ALT) || phase_q);
  end

  // R3: in alternate mode two ticks never come back to back
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == STEP_ALT && tick_o) |=> (mode_i != STEP_ALT || !tick_o));
endmodule

// File: rtl/gsc_ramp.sv
module gsc_ramp #(
  parameter int GAIN_W   = 7,
  parameter int SAT_CODE = 119
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              power_i,
  input  logic              tick_i,
  input  logic              jump_i,
  input  logic [GAIN_W-1:0] target_i,
  output logic [GAIN_W-1:0] applied_o
);
  localparam logic [GAIN_W-1:0] ONE   = GAIN_W'(1);
  localparam logic [GAIN_W-1:0] LIMIT = GAIN_W'(SAT_CODE);

  logic [GAIN_W-1:0] applied_q;
  logic [GAIN_W-1:0] applied_d;

  always_comb begin
    applied_d = applied_q;
    if (!power_i) begin
      applied_d = '0;
    end else if (tick_i) begin
      if (jump_i) begin
        applied_d = target_i;
      end else if (applied_q < target_i) begin
        applied_d = applied_q + ONE;
      end else if (applied_q > target_i) begin
        applied_d = applied_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) applied_q <= '0;
    else        applied_q <= applied_d;
  end

  assign applied_o = applied_q;

  // R5: no tick, no movement while powered
  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (power_i && !tick_i) |=> $stable(applied_q));
  // R2: a paced step moves at most one code
  a_r2_single_code: assert property (@(posedge clk) disable iff (!rst_n)
    (power_i && tick_i && !jump_i) |=>
      (applied_q == $past(applied_q) || applied_q == $past(applied_q) + ONE ||
       applied_q == $past(applied_q) - ONE));
  // R6: never above the saturation code
  a_r6_saturated: assert property (@(posedge clk) disable iff (!rst_n)
    applied_q <= LIMIT);
  // R8: power off forces zero
  a_r8_powered_down_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !power_i |=> applied_q == '0);
endmodule

// File: rtl/gain_slew_ctrl.sv
module gain_slew_ctrl
  import gsc_pkg::*;
#(
  parameter int GAIN_W   = 7,
  parameter int SAT_CODE = 119
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GAIN_W-1:0] gain_set_i,
  input  logic              mute_set_i,
  input  logic [1:0]        step_mode_i,
  input  logic              power_on_i,
  input  logic              fs_strobe_i,
  output logic [GAIN_W-1:0] gain_applied_o,
  output logic              mute_eff_o,
  output logic              at_target_o,
  output logic              power_state_o
);
  logic [GAIN_W-1:0] target_sat;
  logic              tick;
  logic              jump;
  logic              mute_q;
  logic              power_q;
  step_mode_e        mode;

  assign mode = step_mode_e'(step_mode_i);

  gsc_clamp #(.GAIN_W(GAIN_W), .SAT_CODE(SAT_CODE)) u_clamp (
    .code_i (gain_set_i),
    .code_o (target_sat)
  );

  gsc_pacer u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .power_i  (power_on_i),
    .strobe_i (fs_strobe_i),
    .mode_i   (mode),
    .tick_o   (tick),
    .jump_o   (jump)
  );

  gsc_ramp #(.GAIN_W(GAIN_W), .SAT_CODE(SAT_CODE)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .power_i   (power_on_i),
    .tick_i    (tick),
    .jump_i    (jump),
    .target_i  (target_sat),
    .applied_o (gain_applied_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_q  <= 1'b1;
      power_q <= 1'b0;
    end else begin
      mute_q  <= mute_set_i;
      power_q <= power_on_i;
    end
  end

  assign mute_eff_o    = mute_q;
  assign power_state_o = power_q;
  assign at_target_o   = power_q && (gain_applied_o == target_sat);

  // R7: flag only while powered and never above saturation
  a_r7_flag_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    at_target_o |-> (power_state_o && gain_applied_o <= GAIN_W'(SAT_CODE)));
  // R4: jump mode lands on target after a strobe
  a_r4_jump_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (power_on_i && fs_strobe_i && step_mode_i[1]) |=>
      gain_applied_o == $past(target_sat));
  // R9: mute output tracks previous request
  a_r9_mute_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute_eff_o) |-> $past(mute_set_i));
endmodule

// File: tb/gain_slew_ctrl_bench.sv
module gain_slew_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] gain_set = '0;
  logic       mute_set = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       pwr = 1'b0;
  logic       stb = 1'b0;
  logic [6:0] g_out;
  logic       m_out, t_out, p_out;

  int checks = 0;
  int failures = 0;

  logic [6:0] m_app = '0;
  logic       m_ph = 1'b0;
  logic       m_mute = 1'b1;
  logic       m_pwr = 1'b0;

  always #10 clk = ~clk;

  gain_slew_ctrl u_gain_slew_ctrl (
    .clk(clk), .rst_n(rst_n), .gain_set_i(gain_set), .mute_set_i(mute_set),
    .step_mode_i(mode), .power_on_i(pwr), .fs_strobe_i(stb),
    .gain_applied_o(g_out), .mute_eff_o(m_out), .at_target_o(t_out),
    .power_state_o(p_out)
  );

  function automatic logic [6:0] sat(input logic [6:0] c);
    return (c > 7'h77) ? 7'h77 : c;
  endfunction

  function automatic logic [6:0] next_gain(input logic [6:0] a, input logic [6:0] t);
    if (a < t) return a + 7'd1;
    if (a > t) return a - 7'd1;
    return a;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2/R3/R4/R5/R6/R8 gain", g_out, m_app);
    chk("R9 mute", m_out, m_mute);
    chk("R10 power", p_out, m_pwr);
    chk("R7 at_target", t_out, (m_pwr && m_app == sat(gain_set)));
  endtask

  // drive at negedge, model the edge, compare at next negedge
  task automatic cyc(input logic [6:0] g, input logic mu, input logic [1:0] md,
                     input logic pu, input logic st);
    gain_set = g; mute_set = mu; mode = md; pwr = pu; stb = st;
    @(posedge clk);
    if (!pu) begin
      m_app = '0; m_ph = 1'b0;
    end else begin
      if (st) begin
        case (md)
          2'b00: m_app = next_gain(m_app, sat(g));
          2'b01: if (m_ph) m_app = next_gain(m_app, sat(g));
          default: m_app = sat(g);
        endcase
      end
      if (md != 2'b01) m_ph = 1'b0;
      else if (st) m_ph = ~m_ph;
    end
    m_mute = mu; m_pwr = pu;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 gain", g_out, 0);
    chk("R1 mute", m_out, 1);
    chk("R1 power", p_out, 0);
    chk("R1 at_target", t_out, 0);
    rst_n = 1'b1;
    cyc(7'h10, 1'b1, 2'b00, 1'b0, 1'b1);
    chk("R8 gain held while off", g_out, 0);
    // R6 ramp into saturation with every-strobe pacing, muted (R9)
    for (int i = 0; i < 130; i++) cyc(7'h7F, 1'b1, 2'b00, 1'b1, 1'b1);
    chk("R6 saturated value", g_out, 7'h77);
    chk("R7 flag at saturation", t_out, 1);
    // R5 no strobe holds
    for (int i = 0; i < 5; i++) cyc(7'h00, 1'b0, 2'b00, 1'b1, 1'b0);
    chk("R5 held", g_out, 7'h77);
    // R3 alternate pacing from a fresh count
    cyc(7'h00, 1'b0, 2'b01, 1'b1, 1'b1);
    chk("R3 first strobe no step", g_out, 7'h77);
    cyc(7'h00, 1'b0, 2'b01, 1'b1, 1'b1);
    chk("R3 second strobe steps", g_out, 7'h76);
    // R4 jump in both disabled modes
    cyc(7'h05, 1'b0, 2'b10, 1'b1, 1'b1);
    chk("R4 jump 10", g_out, 7'h05);
    cyc(7'h7A, 1'b0, 2'b11, 1'b1, 1'b1);
    chk("R4 jump 11 saturated", g_out, 7'h77);
    // R8 power drop then restart from zero
    cyc(7'h20, 1'b0, 2'b00, 1'b0, 1'b0);
    chk("R8 forced zero", g_out, 0);
    cyc(7'h20, 1'b0, 2'b00, 1'b1, 1'b1);
    chk("R8 restart from zero", g_out, 1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [6:0] g;
      logic [1:0] md;
      g = ($urandom % 4 == 0) ? 7'(7'h70 + $urandom % 16) : 7'($urandom);
      md = ($urandom % 8 == 0) ? 2'($urandom) : mode;
      cyc(($urandom % 10 == 0) ? g : gain_set, 1'($urandom), md,
          ($urandom % 60 == 0) ? ~pwr : 1'b1, ($urandom % 3 == 0));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule